// File: doc/BRIEF.md
# Counter-Increment-Modifier Index Register File

This block holds a bank of index registers for a stack-oriented processor. Every entry packs three 16-bit fields: a loop counter, a step increment and an address modifier. One operation per cycle loads, reads, updates or copies these fields. An access operation forms an effective address from a base value and the modifier of the selected entry. The auto-increment form of that access also moves the modifier on by its own step and counts the counter down by one.

The surrounding pipeline supplies an operation code, a source entry number, a destination entry number (used only by copies), a 48-bit data word and a 16-bit base. Read-back data and the effective address come out one clock after the operation. A per-entry flag shows which counters are at zero, so that the loop-jump logic can test them without a read. All field arithmetic wraps modulo 2^16.

Top module: `cim_index_file`

## Requirements
- R1: A whole entry is packed as counter in bits 47:32, increment in 31:16 and modifier in 15:0. OP_LD_ALL writes all three fields from the data word, and OP_RD_ALL returns them in that layout.
- R2: OP_LD_M, OP_LD_I and OP_LD_C write bits 15:0 of the data word into one field and leave the other two unchanged. OP_RD_M, OP_RD_I and OP_RD_C return that field zero-extended to 48 bits.
- R3: OP_RLD_M, OP_RLD_I and OP_RLD_C first force the entry to counter 0, increment 1 and modifier 0, and then write bits 15:0 of the data word into the named field.
- R4: OP_MOD_INC adds the entry's own increment to its modifier. OP_MOD_DEC subtracts it.
- R5: OP_CNT_NEG replaces the counter with its two's-complement negation. OP_CNT_DEC lowers the counter by one, so that 0 becomes 0xFFFF.
- R6: OP_INC_P1, OP_INC_M1, OP_INC_P2 and OP_INC_M2 set the increment to 0x0001, 0xFFFF, 0x0002 and 0xFFFE.
- R7: The copy operations move fields from entry sel_src into entry sel_dst and leave the destination's other fields alone. OP_CP_M, OP_CP_I and OP_CP_C copy one field. OP_CP_IM, OP_CP_CM and OP_CP_CI copy the named pair. OP_CP_ALL copies the whole entry.
- R8: OP_ADD_M, OP_ADD_I and OP_ADD_C add bits 15:0 of the data word to one field, wrapping at 16 bits. OP_ADD_ALL adds each 16-bit lane of the data word to the matching field, with no carry between lanes.
- R9: OP_ACC and OP_ACC_AUTO present base_addr + modifier + next_word (mod 2^16) on addr_out, with addr_valid high, in the cycle after the operation. addr_valid is low after any other operation.
- R10: OP_ACC_AUTO issues its address from the modifier value held before the operation. In the same clock it sets the modifier to modifier + increment and the counter to counter - 1.
- R11: cz_flags[n] is high exactly when the counter of entry n is zero, and it follows each write one clock after the operation.
- R12: Reset clears every field of every entry, so all zero flags are high and both valid outputs are low. A cycle with op_valid low changes no entry.
- R13: rd_data carries the result of a read operation in the next cycle. rd_valid is high only in the cycle after a read operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Operation present this cycle |
| op_code | input | 5 | Operation, encoded as cim_op_e |
| sel_src | input | 4 | Entry operated on, or copy source |
| sel_dst | input | 4 | Copy destination entry |
| wdata | input | 48 | Data word for loads and adds |
| base_addr | input | 16 | Base for effective address |
| next_word | input | 1 | Adds one to the effective address |
| addr_out | output | 16 | Registered effective address |
| addr_valid | output | 1 | addr_out is from an access this cycle |
| rd_data | output | 48 | Registered read-back data |
| rd_valid | output | 1 | rd_data is from a read this cycle |
| cz_flags | output | 16 | Per-entry counter-is-zero flags |

## Verification
The assertions assume that op_code is one of the 32 defined operations, and that sel_src and sel_dst are held stable for the cycle in which op_valid is high. The assertions compare the update unit's write value with the bank's read value during that same cycle. For that reason they also assume that only one operation enters per clock, which the interface enforces. The stimulus drives every input at the falling edge, changes it only between operations, and uses only enumerated operation values. It includes the idle cycle with op_valid low that R12 needs.

// File: rtl/cim_pkg.sv
package cim_pkg;

  localparam int unsigned FW = 16;
  localparam int unsigned WW = 3 * FW;

  typedef logic [FW-1:0] fld_t;

  typedef struct packed {
    fld_t cnt;
    fld_t inc;
    fld_t mod;
  } cim_reg_t;

  typedef enum logic [4:0] {
    OP_LD_M, OP_LD_I, OP_LD_C, OP_LD_ALL,
    OP_RLD_M, OP_RLD_I, OP_RLD_C,
    OP_RD_M, OP_RD_I, OP_RD_C, OP_RD_ALL,
    OP_ADD_M, OP_ADD_I, OP_ADD_C, OP_ADD_ALL,
    OP_MOD_INC, OP_MOD_DEC,
    OP_CNT_NEG, OP_CNT_DEC,
    OP_INC_P1, OP_INC_M1, OP_INC_P2, OP_INC_M2,
    OP_CP_M, OP_CP_I, OP_CP_C, OP_CP_IM, OP_CP_CM, OP_CP_CI, OP_CP_ALL,
    OP_ACC, OP_ACC_AUTO
  } cim_op_e;

  localparam cim_reg_t RESET_FORM = '{cnt: '0, inc: fld_t'(1), mod: '0};

  function automatic fld_t f_add(input fld_t a, input fld_t b);
    return a + b;
  endfunction

  function automatic fld_t f_sub(input fld_t a, input fld_t b);
    return a - b;
  endfunction

  function automatic fld_t f_neg(input fld_t a);
    return (~a) + fld_t'(1);
  endfunction

  function automatic cim_reg_t f_lane_add(input cim_reg_t a, input cim_reg_t b);
    cim_reg_t r;
    r.cnt = f_add(a.cnt, b.cnt);
    r.inc = f_add(a.inc, b.inc);
    r.mod = f_add(a.mod, b.mod);
    return r;
  endfunction

  function automatic fld_t f_ea(input fld_t base, input fld_t mod, input logic nxt);
    return base + mod + fld_t'(nxt);
  endfunction

  function automatic logic f_is_read(input cim_op_e op);
    return op inside {OP_RD_M, OP_RD_I, OP_RD_C, OP_RD_ALL};
  endfunction

  function automatic logic f_is_copy(input cim_op_e op);
    return op inside {OP_CP_M, OP_CP_I, OP_CP_C, OP_CP_IM, OP_CP_CM, OP_CP_CI, OP_CP_ALL};
  endfunction

  function automatic logic f_is_access(input cim_op_e op);
    return op inside {OP_ACC, OP_ACC_AUTO};
  endfunction

endpackage

// File: rtl/cim_update.sv
module cim_update
  import cim_pkg::*;
(
  input  logic          valid,
  input  cim_op_e       op,
  input  cim_reg_t      src_val,
  input  cim_reg_t      dst_val,
  input  logic [WW-1:0] wdata,
  output logic          wr_en,
  output logic          wr_to_dst,
  output cim_reg_t      wr_val
);

  fld_t     lo;
  cim_reg_t wd;

  assign lo = wdata[FW-1:0];
  assign wd = cim_reg_t'(wdata);

  always_comb begin
    wr_en     = valid;
    wr_to_dst = valid && f_is_copy(op);
    wr_val    = src_val;
    case (op)
      OP_LD_M:     wr_val.mod = lo;
      OP_LD_I:     wr_val.inc = lo;
      OP_LD_C:     wr_val.cnt = lo;
      OP_LD_ALL:   wr_val = wd;
      OP_RLD_M:    begin wr_val = RESET_FORM; wr_val.mod = lo; end
      OP_RLD_I:    begin wr_val = RESET_FORM; wr_val.inc = lo; end
      OP_RLD_C:    begin wr_val = RESET_FORM; wr_val.cnt = lo; end
      OP_ADD_M:    wr_val.mod = f_add(src_val.mod, lo);
      OP_ADD_I:    wr_val.inc = f_add(src_val.inc, lo);
      OP_ADD_C:    wr_val.cnt = f_add(src_val.cnt, lo);
      OP_ADD_ALL:  wr_val = f_lane_add(src_val, wd);
      OP_MOD_INC:  wr_val.mod = f_add(src_val.mod, src_val.inc);
      OP_MOD_DEC:  wr_val.mod = f_sub(src_val.mod, src_val.inc);
      OP_CNT_NEG:  wr_val.cnt = f_neg(src_val.cnt);
      OP_CNT_DEC:  wr_val.cnt = f_sub(src_val.cnt, fld_t'(1));
      OP_INC_P1:   wr_val.inc = fld_t'(1);
      OP_INC_M1:   wr_val.inc = f_neg(fld_t'(1));
      OP_INC_P2:   wr_val.inc = fld_t'(2);
      OP_INC_M2:   wr_val.inc = f_neg(fld_t'(2));
      OP_CP_M:     begin wr_val = dst_val; wr_val.mod = src_val.mod; end
      OP_CP_I:     begin wr_val = dst_val; wr_val.inc = src_val.inc; end
      OP_CP_C:     begin wr_val = dst_val; wr_val.cnt = src_val.cnt; end
      OP_CP_IM:    begin wr_val = dst_val; wr_val.inc = src_val.inc; wr_val.mod = src_val.mod; end
      OP_CP_CM:    begin wr_val = dst_val; wr_val.cnt = src_val.cnt; wr_val.mod = src_val.mod; end
      OP_CP_CI:    begin wr_val = dst_val; wr_val.cnt = src_val.cnt; wr_val.inc = src_val.inc; end
      OP_CP_ALL:   wr_val = src_val;
      OP_ACC_AUTO: begin
        wr_val.mod = f_add(src_val.mod, src_val.inc);
        wr_val.cnt = f_sub(src_val.cnt, fld_t'(1));
      end
      default:     wr_en = 1'b0;
    endcase
  end

endmodule

// File: rtl/cim_bank.sv
module cim_bank
  import cim_pkg::*;
#(
  parameter  int unsigned NREG = 16,
  localparam int unsigned SELW = (NREG > 1) ? $clog2(NREG) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            we,
  input  logic [SELW-1:0] widx,
  input  cim_reg_t        wval,
  input  logic [SELW-1:0] ridx_a,
  input  logic [SELW-1:0] ridx_b,
  output cim_reg_t        rval_a,
  output cim_reg_t        rval_b,
  output logic [NREG-1:0] cz_flags
);

  cim_reg_t view [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_ent
    cim_reg_t ent_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ent_q <= '0;
      end else if (we && (widx == SELW'(g))) begin
        ent_q <= wval;
      end
    end

    assign view[g]     = ent_q;
    assign cz_flags[g] = (ent_q.cnt == '0);
  end

  assign rval_a = view[ridx_a];
  assign rval_b = view[ridx_b];

endmodule

// File: rtl/cim_addr_gen.sv
module cim_addr_gen
  import cim_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    valid,
  input  cim_op_e op,
  input  fld_t    base,
  input  fld_t    mod,
  input  logic    nxt,
  output fld_t    addr_q,
  output logic    addr_vld_q
);

  logic fire;
  assign fire = valid && f_is_access(op);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q     <= '0;
      addr_vld_q <= 1'b0;
    end else begin
      addr_vld_q <= fire;
      if (fire) addr_q <= f_ea(base, mod, nxt);
    end
  end

endmodule

// File: rtl/cim_index_file.sv
module cim_index_file
  import cim_pkg::*;
#(
  parameter  int unsigned NREG = 16,
  localparam int unsigned SELW = (NREG > 1) ? $clog2(NREG) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            op_valid,
  input  logic [4:0]      op_code,
  input  logic [SELW-1:0] sel_src,
  input  logic [SELW-1:0] sel_dst,
  input  logic [WW-1:0]   wdata,
  input  logic [FW-1:0]   base_addr,
  input  logic            next_word,
  output logic [FW-1:0]   addr_out,
  output logic            addr_valid,
  output logic [WW-1:0]   rd_data,
  output logic            rd_valid,
  output logic [NREG-1:0] cz_flags
);

  cim_op_e         op;
  cim_reg_t        rd_a;
  cim_reg_t        rd_b;
  cim_reg_t        upd_val;
  logic            upd_we;
  logic            upd_to_dst;
  logic [SELW-1:0] wr_idx;
  logic [WW-1:0]   rd_next;
  logic            rd_fire;

  assign op     = cim_op_e'(op_code);
  assign wr_idx = upd_to_dst ? sel_dst : sel_src;

  cim_bank #(.NREG(NREG)) u_bank (
    .clk      (clk),
    .rst_n    (rst_n),
    .we       (upd_we),
    .widx     (wr_idx),
    .wval     (upd_val),
    .ridx_a   (sel_src),
    .ridx_b   (sel_dst),
    .rval_a   (rd_a),
    .rval_b   (rd_b),
    .cz_flags (cz_flags)
  );

  cim_update u_upd (
    .valid     (op_valid),
    .op        (op),
    .src_val   (rd_a),
    .dst_val   (rd_b),
    .wdata     (wdata),
    .wr_en     (upd_we),
    .wr_to_dst (upd_to_dst),
    .wr_val    (upd_val)
  );

  cim_addr_gen u_agen (
    .clk        (clk),
    .rst_n      (rst_n),
    .valid      (op_valid),
    .op         (op),
    .base       (base_addr),
    .mod        (rd_a.mod),
    .nxt        (next_word),
    .addr_q     (addr_out),
    .addr_vld_q (addr_valid)
  );

  assign rd_fire = op_valid && f_is_read(op);

  always_comb begin
    case (op)
      OP_RD_M: rd_next = WW'(rd_a.mod);
      OP_RD_I: rd_next = WW'(rd_a.inc);
      OP_RD_C: rd_next = WW'(rd_a.cnt);
      default: rd_next = rd_a;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_data  <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= rd_fire;
      if (rd_fire) rd_data <= rd_next;
    end
  end

endmodule

// File: rtl/cim_checker.sv
module cim_checker
  import cim_pkg::*;
#(
  parameter  int unsigned NREG = 16,
  localparam int unsigned SELW = (NREG > 1) ? $clog2(NREG) : 1
) (
  input logic            clk,
  input logic            rst_n,
  input logic            op_valid,
  input logic [4:0]      op_code,
  input logic [SELW-1:0] sel_src,
  input logic [FW-1:0]   wdata_lo,
  input logic [FW-1:0]   base_addr,
  input logic            next_word,
  input logic [FW-1:0]   addr_out,
  input logic            addr_valid,
  input logic            rd_valid,
  input logic [NREG-1:0] cz_flags,
  input cim_reg_t        src_val,
  input logic            upd_we,
  input cim_reg_t        upd_val
);

  cim_op_e op;
  logic    is_rd;
  logic    is_acc;
  fld_t    ea_exp;
  fld_t    mod_step;
  fld_t    cnt_step;

  assign op       = cim_op_e'(op_code);
  assign is_rd    = (op == OP_RD_M) || (op == OP_RD_I) || (op == OP_RD_C) || (op == OP_RD_ALL);
  assign is_acc   = (op == OP_ACC) || (op == OP_ACC_AUTO);
  assign ea_exp   = base_addr + src_val.mod + fld_t'(next_word);
  assign mod_step = src_val.mod + src_val.inc;
  assign cnt_step = src_val.cnt - fld_t'(1);

  // R9: the address unit output matches base plus the bank's modifier
  a_r9_addr: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && is_acc) |=> (addr_valid && addr_out == $past(ea_exp)));

  a_r9_addr_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !(op_valid && is_acc) |=> !addr_valid);

  // R10: the auto step writes back the stepped modifier and counter
  a_r10_auto_step: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op == OP_ACC_AUTO) |->
      (upd_we && upd_val.mod == mod_step && upd_val.cnt == cnt_step && upd_val.inc == src_val.inc));

  // R3: the reset-load form produces the fixed pattern around the loaded field
  a_r3_reset_form: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op == OP_RLD_M) |->
      (upd_we && upd_val.cnt == '0 && upd_val.inc == fld_t'(1) && upd_val.mod == wdata_lo));

  // R11: loading a zero counter raises the flag of that entry
  a_r11_cz_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op == OP_LD_C && wdata_lo == '0) |=> cz_flags[$past(sel_src)]);

  a_r11_cz_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op == OP_LD_C && wdata_lo != '0) |=> !cz_flags[$past(sel_src)]);

  // R12: an idle cycle leaves every counter flag as it was
  a_r12_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid |=> $stable(cz_flags));

  // R13: read strobe follows read operations only
  a_r13_rd_valid: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && is_rd) |=> rd_valid);

  a_r13_rd_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !(op_valid && is_rd) |=> !rd_valid);

endmodule

bind cim_index_file cim_checker #(.NREG(NREG)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .op_valid   (op_valid),
  .op_code    (op_code),
  .sel_src    (sel_src),
  .wdata_lo   (wdata[cim_pkg::FW-1:0]),
  .base_addr  (base_addr),
  .next_word  (next_word),
  .addr_out   (addr_out),
  .addr_valid (addr_valid),
  .rd_valid   (rd_valid),
  .cz_flags   (cz_flags),
  .src_val    (rd_a),
  .upd_we     (upd_we),
  .upd_val    (upd_val)
);

// File: tb/cim_index_file_tb.sv
`timescale 1ns/1ps
module cim_index_file_tb;
  import cim_pkg::*;

  localparam int NREG = 16;
  localparam int SELW = 4;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            op_valid = 1'b0;
  logic [4:0]      op_code = '0;
  logic [SELW-1:0] sel_src = '0;
  logic [SELW-1:0] sel_dst = '0;
  logic [47:0]     wdata = '0;
  logic [15:0]     base_addr = '0;
  logic            next_word = 1'b0;
  logic [15:0]     addr_out;
  logic            addr_valid;
  logic [47:0]     rd_data;
  logic            rd_valid;
  logic [NREG-1:0] cz_flags;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  cim_index_file #(.NREG(NREG)) u_dut (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
    .sel_src(sel_src), .sel_dst(sel_dst), .wdata(wdata), .base_addr(base_addr),
    .next_word(next_word), .addr_out(addr_out), .addr_valid(addr_valid),
    .rd_data(rd_data), .rd_valid(rd_valid), .cz_flags(cz_flags)
  );

  // chk: 0 = none, 1 = compare rd_data, 2 = compare addr_out
  typedef struct packed {
    logic [4:0]  op;
    logic [3:0]  a;
    logic [3:0]  b;
    logic [47:0] d;
    logic [15:0] base;
    logic        nxt;
    logic [1:0]  chk;
    logic [47:0] exp;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 46;
  localparam vec_t VECS [NV] = '{
    '{OP_LD_ALL,   4'd2, 4'd0, 48'h0003_0005_0010, 16'h0000, 1'b0, 2'd0, 48'h0,              4'd1},
    '{OP_RD_ALL,   4'd2, 4'd0, 48'h0,              16'h0000, 1'b0, 2'd1, 48'h0003_0005_0010, 4'd1},  // R1
    '{OP_ACC,      4'd2, 4'd0, 48'h0,              16'h0100, 1'b0, 2'd2, 48'h0110,           4'd9},  // R9
    '{OP_ACC,      4'd2, 4'd0, 48'h0,              16'h0100, 1'b1, 2'd2, 48'h0111,           4'd9},  // R9
    '{OP_ACC_AUTO, 4'd2, 4'd0, 48'h0,              16'h0200, 1'b0, 2'd2, 48'h0210,           4'd10}, // R10
    '{OP_RD_ALL,   4'd2, 4'd0, 48'h0,              16'h0000, 1'b0, 2'd1, 48'h0002_0005_0015, 4'd10}, // R10
    '{OP_MOD_DEC,  4'd2, 4'd0, 48'h0,              16'h0000, 1'b0, 2'd0, 48'h0,              4'd4},
    '{OP_RD_M,     4'd2, 4'd0, 48'h0,              16'h0000, 1'b0, 2'd1, 48'h0010,           4'd4},  // R4
    '{OP_CNT_NEG,  4'd2, 4'd0, 48'h0,              16'h0000, 1'b0, 2'd0, 48'h0,              4'd5},
    '{OP_RD_C,     4'd2, 4'd0, 48'h0,              16'h0000, 1'b0, 2'd1, 48'hFFFE,           4'd5},  // R5
    '{OP_CNT_DEC,  4'd2, 4'd0, 48'h0,              16'h0000, 1'b0, 2'd0, 48'h0,              4'd5},
    '{OP_RD_C,     4'd2, 4'd0, 48'h0,              16'h0000, 1'b0, 2'd1, 48'hFFFD,           4'd5},  // R5
    '{OP_INC_M2,   4'd2, 4'd0, 48'h0,              16'h0000, 1'b0, 2'd0, 48'h0,              4'd6},
    '{OP_RD_I,     4'd2, 4'd0, 48'h0,              16'h0000, 1'b0, 2'd1, 48'hFFFE,           4'd6},  // R6
    '{OP_MOD_INC,  4'd2, 4'd0, 48'h0,              16'h0000, 1'b0, 2'd0, 48'h0,              4'd4},
    '{OP_RD_M,     4'd2, 4'd0, 48'h0,              16'h0000, 1'b0, 2'd1, 48'h000E,           4'd4},  // R4
    '{OP_RLD_M,    4'd3, 4'd0, 48'h0000_ABCD_1234, 16'h0000, 1'b0, 2'd0, 48'h0,              4'd3},
    '{OP_RD_ALL,   4'd3, 4'd0, 48'h0,              16'h0000, 1'b0, 2'd1, 48'h0000_0001_1234, 4'd3},  // R3
    '{OP_LD_C,     4'd3, 4'd0, 48'hFFFF_FFFF_0007, 16'h0000, 1'b0, 2'd0, 48'h0,              4'd2},
    '{OP_RD_ALL,   4'd3, 4'd0, 48'h0,              16'h0000, 1'b0, 2'd1, 48'h0007_0001_1234, 4'd2},  // R2
    '{OP_RLD_I,    4'd3, 4'd0, 48'h0000_0000_0009, 16'h0000, 1'b0, 2'd0, 48'h0,              4'd3},
    '{OP_RD_ALL,   4'd3, 4'd0, 48'h0,              16'h0000, 1'b0, 2'd1, 48'h0000_0009_0000, 4'd3},  // R3
    '{OP_CP_CM,    4'd2, 4'd3, 48'h0,              16'h0000, 1'b0, 2'd0, 48'h0,              4'd7},
    '{OP_RD_ALL,   4'd3, 4'd0, 48'h0,              16'h0000, 1'b0, 2'd1, 48'hFFFD_0009_000E, 4'd7},  // R7
    '{OP_ADD_M,    4'd3, 4'd0, 48'h0000_0000_FFF5, 16'h0000, 1'b0, 2'd0, 48'h0,              4'd8},
    '{OP_RD_M,     4'd3, 4'd0, 48'h0,              16'h0000, 1'b0, 2'd1, 48'h0003,           4'd8},  // R8
    '{OP_ADD_ALL,  4'd3, 4'd0, 48'h0001_0001_0001, 16'h0000, 1'b0, 2'd0, 48'h0,              4'd8},
    '{OP_RD_ALL,   4'd3, 4'd0, 48'h0,              16'h0000, 1'b0, 2'd1, 48'hFFFE_000A_0004, 4'd8},  // R8
    '{OP_CP_ALL,   4'd3, 4'd5, 48'h0,              16'h0000, 1'b0, 2'd0, 48'h0,              4'd7},
    '{OP_RD_ALL,   4'd5, 4'd0, 48'h0,              16'h0000, 1'b0, 2'd1, 48'hFFFE_000A_0004, 4'd7},  // R7
    '{OP_INC_P2,   4'd5, 4'd0, 48'h0,              16'h0000, 1'b0, 2'd0, 48'h0,              4'd6},
    '{OP_CP_I,     4'd5, 4'd0, 48'h0,              16'h0000, 1'b0, 2'd0, 48'h0,              4'd7},
    '{OP_RD_ALL,   4'd0, 4'd0, 48'h0,              16'h0000, 1'b0, 2'd1, 48'h0000_0002_0000, 4'd7},  // R7
    '{OP_INC_M1,   4'd0, 4'd0, 48'h0,              16'h0000, 1'b0, 2'd0, 48'h0,              4'd6},
    '{OP_RD_I,     4'd0, 4'd0, 48'h0,              16'h0000, 1'b0, 2'd1, 48'hFFFF,           4'd6},  // R6
    '{OP_LD_M,     4'd0, 4'd0, 48'h1234_5678_9ABC, 16'h0000, 1'b0, 2'd0, 48'h0,              4'd2},
    '{OP_RD_ALL,   4'd0, 4'd0, 48'h0,              16'h0000, 1'b0, 2'd1, 48'h0000_FFFF_9ABC, 4'd2},  // R2
    '{OP_CP_CI,    4'd3, 4'd0, 48'h0,              16'h0000, 1'b0, 2'd0, 48'h0,              4'd7},
    '{OP_RD_ALL,   4'd0, 4'd0, 48'h0,              16'h0000, 1'b0, 2'd1, 48'hFFFE_000A_9ABC, 4'd7},  // R7
    '{OP_ADD_C,    4'd0, 4'd0, 48'h0000_0000_0003, 16'h0000, 1'b0, 2'd0, 48'h0,              4'd8},
    '{OP_RD_C,     4'd0, 4'd0, 48'h0,              16'h0000, 1'b0, 2'd1, 48'h0001,           4'd8},  // R8
    '{OP_INC_P1,   4'd0, 4'd0, 48'h0,              16'h0000, 1'b0, 2'd0, 48'h0,              4'd6},
    '{OP_RD_I,     4'd0, 4'd0, 48'h0,              16'h0000, 1'b0, 2'd1, 48'h0001,           4'd6},  // R6
    '{OP_RLD_C,    4'd6, 4'd0, 48'h0000_0000_0042, 16'h0000, 1'b0, 2'd0, 48'h0,              4'd3},
    '{OP_RD_ALL,   4'd6, 4'd0, 48'h0,              16'h0000, 1'b0, 2'd1, 48'h0042_0001_0000, 4'd3},  // R3
    '{OP_ACC,      4'd6, 4'd0, 48'h0,              16'hFFFF, 1'b1, 2'd2, 48'h0000,           4'd9}   // R9 wrap
  };

  task automatic check(input string req, input string what, input logic [47:0] act, input logic [47:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // Called at a falling edge; returns at the next falling edge with results visible.
  task automatic issue(input logic [4:0] o, input logic [3:0] a, input logic [3:0] b,
                       input logic [47:0] d, input logic [15:0] bs, input logic n, input logic v);
    op_code   = o;
    sel_src   = a;
    sel_dst   = b;
    wdata     = d;
    base_addr = bs;
    next_word = n;
    op_valid  = v;
    @(negedge clk);
    op_valid  = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R12: reset state
    check("R12", "cz_flags after reset", 48'(cz_flags), 48'hFFFF);
    check("R12", "rd_valid after reset", 48'(rd_valid), 48'h0);
    check("R12", "addr_valid after reset", 48'(addr_valid), 48'h0);
    rst_n = 1'b1;
    @(negedge clk);
    issue(OP_RD_ALL, 4'd9, 4'd0, 48'h0, 16'h0, 1'b0, 1'b1);
    check("R12", "entry contents after reset", rd_data, 48'h0);

    for (int i = 0; i < NV; i++) begin
      string rq;
      issue(VECS[i].op, VECS[i].a, VECS[i].b, VECS[i].d, VECS[i].base, VECS[i].nxt, 1'b1);
      rq = $sformatf("R%0d", VECS[i].req);
      if (VECS[i].chk == 2'd1) begin
        check("R13", "rd_valid after read", 48'(rd_valid), 48'h1);
        check(rq, $sformatf("rd_data row %0d", i), rd_data, VECS[i].exp);
      end else if (VECS[i].chk == 2'd2) begin
        check("R9", "addr_valid after access", 48'(addr_valid), 48'h1);
        check("R13", "rd_valid after access", 48'(rd_valid), 48'h0);
        check(rq, $sformatf("addr_out row %0d", i), 48'(addr_out), VECS[i].exp);
      end
    end

    // R12: a load with op_valid low changes nothing
    issue(OP_LD_ALL, 4'd2, 4'd0, 48'h0, 16'h0, 1'b0, 1'b0);
    check("R9", "addr_valid when idle", 48'(addr_valid), 48'h0);
    issue(OP_RD_ALL, 4'd2, 4'd0, 48'h0, 16'h0, 1'b0, 1'b1);
    check("R12", "entry unchanged by idle cycle", rd_data, 48'hFFFD_FFFE_000E);

    // R11: counter-zero flag tracking
    issue(OP_LD_C, 4'd7, 4'd0, 48'h0000_0000_0001, 16'h0, 1'b0, 1'b1);
    check("R11", "cz[7] after load 1", 48'(cz_flags[7]), 48'h0);
    check("R11", "cz[9] untouched", 48'(cz_flags[9]), 48'h1);
    issue(OP_ACC_AUTO, 4'd7, 4'd0, 48'h0, 16'h0040, 1'b0, 1'b1);
    check("R10", "auto access address", 48'(addr_out), 48'h0040);
    check("R11", "cz[7] after auto step to zero", 48'(cz_flags[7]), 48'h1);
    issue(OP_CNT_DEC, 4'd7, 4'd0, 48'h0, 16'h0, 1'b0, 1'b1);
    check("R11", "cz[7] after wrap", 48'(cz_flags[7]), 48'h0);
    issue(OP_RD_C, 4'd7, 4'd0, 48'h0, 16'h0, 1'b0, 1'b1);
    check("R5", "counter wraps below zero", rd_data, 48'hFFFF);
    issue(OP_RD_M, 4'd7, 4'd0, 48'h0, 16'h0, 1'b0, 1'b1);
    check("R10", "modifier stepped by zero increment", rd_data, 48'h0);
    issue(OP_LD_C, 4'd7, 4'd0, 48'hFFFF_FFFF_0000, 16'h0, 1'b0, 1'b1);
    check("R11", "cz[7] after load 0", 48'(cz_flags[7]), 48'h1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule